// File: doc/BRIEF.md
# Two-Level Interrupt Priority Resolver

This block chooses one interrupt out of 54 request lines and presents it to a processor core. Each line has a pending flag and an enable bit, and each source has a programmable 3-bit level. The level is compared first. When two or more competing requests share the top level, the request with the lowest index wins. The chosen source's index, its vector number (index + 8) and its level are registered. A request signal is raised when that level is strictly above the core's current level.

The per-source levels are held in a small bank of 16-bit configuration words. Each word packs four sources, one per 4-bit nibble. A simple synchronous write port and a combinational read port give access to the words. A fixed set of indices is reserved. Those indices never take part in the arbitration.

Top module: `irq_level_arbiter`

## Requirements
- R1: During synchronous reset (`rst` high at a clock edge), the winner index, vector and level registers clear to 0 and every source level is set to 4. Afterwards each existing word reads 0x4444 until it is written.
- R2: A source competes only when its pending bit, its enable bit and a non-zero level are all present at the same clock edge. A source at level 0 is never selected.
- R3: Among the competing sources, the one with the highest level wins, whatever the indices. For example, index 43 at level 7 beats index 0 at level 1.
- R4: When several competing sources share the highest level, the one with the lowest index wins.
- R5: The vector output equals the winner index plus 8 (index 0 gives 8, index 53 gives 61). When no source competes, index, vector and level all read 0.
- R6: Indices 26 to 38, 41, 42 and 44 to 53 are reserved. They never win, even when they are pending and enabled.
- R7: `irqReq` is high exactly when the registered winner level is strictly greater than `cpuLevel`. It follows `cpuLevel` without waiting for a clock edge.
- R8: The winner outputs are registered. They reflect the pending, enable and level state of the previous clock edge, one cycle of latency.
- R9: Word w (address w) holds sources 4w to 4w+3. The level of source 4w+k sits in bits 4k+2 to 4k, and bit 4k+3 always reads 0. A write is stored at the clock edge, and the arbitration uses the new level from the following edge. Reads are combinational.
- R10: Addresses 14 and 15 read 0 and ignore writes. The nibbles of word 13 that would belong to the missing sources 54 and 55 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pending | input | 54 | Request pending flags, one per source |
| enable | input | 54 | Request enable bits, one per source |
| cpuLevel | input | 3 | Current level of the core |
| regWrEn | input | 1 | Configuration write strobe |
| regAddr | input | 4 | Configuration word address |
| regWrData | input | 16 | Configuration write data |
| regRdData | output | 16 | Configuration read data for `regAddr` |
| winIdx | output | 6 | Registered winner index |
| winVec | output | 6 | Registered winner vector (index + 8) |
| winLvl | output | 3 | Registered winner level |
| irqReq | output | 1 | Winner level above `cpuLevel` |

## Verification
The bench targets several corner cases:
- A high-index source at a high level competing against index 0 at a low level. A resolver that weighed the index first would pick index 0.
- Ties at equal level. A resolver with a `>=` compare would let the last index win.
- A level-0 source, a disabled source and a reserved source, each pending alone. A faulty design would report one of them instead of the all-zero idle result.
- Equality between `cpuLevel` and the winner level, where a non-strict compare raises a spurious request.
- A level write while the pending state is held. This exposes a design that applies the new level in the same cycle.
- The nibble top bits, word 13 and the unused addresses, where a design storing all 16 bits would echo ones.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int NIB_W      = 4;
  localparam int SRC_PER_WD = 4;
  localparam int CFG_DW     = NIB_W * SRC_PER_WD;
  localparam int WIDX_W     = 8;

  typedef struct packed {
    logic              wrStb;
    logic [WIDX_W-1:0] wordIdx;
    logic [CFG_DW-1:0] wrData;
  } cfgStrobe_t;

  function automatic logic [63:0] reservedMask();
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if ((i >= 26 && i <= 38) || i == 41 || i == 42 || i >= 44) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_WORDS = 14,
  parameter int LVL_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CFG_DW-1:0] regWrData,
  input  logic [LVL_W-1:0]  winLvl,
  input  logic [LVL_W-1:0]  cpuLevel,
  output cfgStrobe_t        cfgStb,
  output logic              irqReq
);

  logic addrOk;

  always_comb begin
    addrOk         = (int'(regAddr) < NUM_WORDS);
    cfgStb.wrStb   = regWrEn && addrOk;
    cfgStb.wordIdx = WIDX_W'(regAddr);
    cfgStb.wrData  = regWrData;
  end

  assign irqReq = (winLvl > cpuLevel);

  // R7
  irq_level_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> (winLvl != '0));

  // R10
  wr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cfgStb.wrStb |-> (regWrEn && int'(cfgStb.wordIdx) < NUM_WORDS));

endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 54,
  parameter int LVL_W     = 3,
  parameter int VEC_BASE  = 8,
  parameter int RST_LVL   = 4,
  parameter int NUM_WORDS = (NUM_SRC + SRC_PER_WD - 1) / SRC_PER_WD,
  parameter int IDX_W     = $clog2(NUM_SRC),
  parameter int VEC_W     = $clog2(NUM_SRC + VEC_BASE)
) (
  input  logic               clk,
  input  logic               rst,
  input  cfgStrobe_t         cfgStb,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [NUM_SRC-1:0] enable,
  input  logic [WIDX_W-1:0]  rdWord,
  output logic [CFG_DW-1:0]  rdData,
  output logic [IDX_W-1:0]   winIdx,
  output logic [VEC_W-1:0]   winVec,
  output logic [LVL_W-1:0]   winLvl
);

  localparam logic [63:0]       RSVD     = reservedMask();
  localparam logic [NIB_W-1:0]  NIB_MASK = NIB_W'({LVL_W{1'b1}});
  localparam logic [CFG_DW-1:0] WD_MASK  = {SRC_PER_WD{NIB_MASK}};

  logic [LVL_W-1:0] prio [NUM_SRC];
  logic [LVL_W-1:0] bestLvl;
  logic [IDX_W-1:0] bestIdx;
  logic [NUM_SRC-1:0] live;

  // level storage, written one word at a time
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) prio[i] <= LVL_W'(RST_LVL);
    end else if (cfgStb.wrStb) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (i / SRC_PER_WD == int'(cfgStb.wordIdx))
          prio[i] <= cfgStb.wrData[(i % SRC_PER_WD) * NIB_W +: LVL_W];
      end
    end
  end

  // combinational readback, unused nibble bits zero
  always_comb begin
    rdData = '0;
    for (int k = 0; k < SRC_PER_WD; k++) begin
      if (int'(rdWord) < NUM_WORDS && int'(rdWord) * SRC_PER_WD + k < NUM_SRC)
        rdData[k * NIB_W +: LVL_W] = prio[int'(rdWord) * SRC_PER_WD + k];
    end
  end

  // live request mask
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_live
      if (RSVD[g]) begin : g_rsvd
        assign live[g] = 1'b0;
      end else begin : g_real
        assign live[g] = pending[g] & enable[g];
      end
    end
  endgenerate

  // level first, lowest index on ties (strict compare keeps earlier index)
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (live[i] && prio[i] > bestLvl) begin
        bestLvl = prio[i];
        bestIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winIdx <= '0;
      winVec <= '0;
      winLvl <= '0;
    end else begin
      winIdx <= bestIdx;
      winLvl <= bestLvl;
      winVec <= (bestLvl != '0) ? VEC_W'(bestIdx) + VEC_W'(VEC_BASE) : '0;
    end
  end

  // R6
  no_reserved_win_chk: assert property (@(posedge clk) disable iff (rst)
    (winLvl != '0) |-> !RSVD[winIdx]);

  // R5
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (winLvl == '0) |-> (winIdx == '0 && winVec == '0));

  // R2
  winner_was_live_chk: assert property (@(posedge clk) disable iff (rst)
    (winLvl != '0) |-> ((($past(pending & enable) >> winIdx) & 1) != 0));

  // R9
  write_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfgStb.wrStb) && rdWord == $past(cfgStb.wordIdx)
     && int'(rdWord) < NUM_WORDS - 1)
    |-> (rdData == ($past(cfgStb.wrData) & WD_MASK)));

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 54,
  parameter int LVL_W    = 3,
  parameter int VEC_BASE = 8,
  parameter int RST_LVL  = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   pending,
  input  logic [NUM_SRC-1:0]   enable,
  input  logic [LVL_W-1:0]     cpuLevel,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [CFG_DW-1:0]    regWrData,
  output logic [CFG_DW-1:0]    regRdData,
  output logic [$clog2(NUM_SRC)-1:0] winIdx,
  output logic [$clog2(NUM_SRC+VEC_BASE)-1:0] winVec,
  output logic [LVL_W-1:0]     winLvl,
  output logic                 irqReq
);

  localparam int NUM_WORDS = (NUM_SRC + SRC_PER_WD - 1) / SRC_PER_WD;

  cfgStrobe_t cfgStb;

  irq_arb_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .LVL_W(LVL_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .winLvl(winLvl), .cpuLevel(cpuLevel),
    .cfgStb(cfgStb), .irqReq(irqReq)
  );

  irq_arb_datapath #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_BASE(VEC_BASE),
    .RST_LVL(RST_LVL), .NUM_WORDS(NUM_WORDS)
  ) i_dp (
    .clk(clk), .rst(rst), .cfgStb(cfgStb), .pending(pending),
    .enable(enable), .rdWord(WIDX_W'(regAddr)), .rdData(regRdData),
    .winIdx(winIdx), .winVec(winVec), .winLvl(winLvl)
  );

endmodule

// File: tb/test_irq_level_arbiter.sv
module test_irq_level_arbiter;

  localparam int N = 54;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] pending = '0;
  logic [N-1:0] enable  = '0;
  logic [2:0]  cpuLevel = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [5:0]  winIdx;
  logic [5:0]  winVec;
  logic [2:0]  winLvl;
  logic        irqReq;

  int checks = 0;
  int fails  = 0;
  int mdl [N];

  always #5 clk = ~clk;

  irq_level_arbiter i_irq_level_arbiter (
    .clk(clk), .rst(rst), .pending(pending), .enable(enable),
    .cpuLevel(cpuLevel), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .winIdx(winIdx),
    .winVec(winVec), .winLvl(winLvl), .irqReq(irqReq)
  );

  function automatic bit isRsvd(int i);
    return (i >= 26 && i <= 38) || i == 41 || i == 42 || i >= 44;
  endfunction

  function automatic int expLvl(logic [N-1:0] p, logic [N-1:0] e);
    int b = 0;
    for (int i = 0; i < N; i++)
      if (p[i] && e[i] && !isRsvd(i) && mdl[i] > b) b = mdl[i];
    return b;
  endfunction

  function automatic int expIdx(logic [N-1:0] p, logic [N-1:0] e);
    int b = 0;
    int bi = 0;
    for (int i = 0; i < N; i++)
      if (p[i] && e[i] && !isRsvd(i) && mdl[i] > b) begin b = mdl[i]; bi = i; end
    return bi;
  endfunction

  function automatic int expRead(int a);
    int v = 0;
    for (int k = 0; k < 4; k++)
      if (a < 14 && a * 4 + k < N) v |= mdl[a * 4 + k] << (4 * k);
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(int a, int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(a); regWrData = 16'(d);
    @(negedge clk);
    regWrEn = 1'b0;
    if (a < 14)
      for (int k = 0; k < 4; k++)
        if (a * 4 + k < N) mdl[a * 4 + k] = (d >> (4 * k)) & 7;
  endtask

  task automatic readCheck(string req, int a);
    regAddr = 4'(a);
    #1;
    check(req, int'(regRdData), expRead(a));
  endtask

  task automatic drive(string req, logic [N-1:0] p, logic [N-1:0] e, int c);
    int el;
    int ei;
    @(negedge clk);
    pending = p; enable = e; cpuLevel = 3'(c);
    @(negedge clk);
    el = expLvl(p, e);
    ei = expIdx(p, e);
    check({req, " level"}, int'(winLvl), el);
    check({req, " index"}, int'(winIdx), ei);
    check({req, " vector"}, int'(winVec), (el != 0) ? ei + 8 : 0);
    check({req, " R7 irqReq"}, int'(irqReq), int'(el > c));
  endtask

  function automatic logic [N-1:0] bits2(int a, int b);
    logic [N-1:0] v = '0;
    v[a] = 1'b1; v[b] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) mdl[i] = 4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 winLvl", int'(winLvl), 0);
    check("R1 winIdx", int'(winIdx), 0);
    check("R1 winVec", int'(winVec), 0);
    check("R1 irqReq", int'(irqReq), 0);
    readCheck("R1 word0", 0);
    check("R1 word0 value", int'(regRdData), 16'h4444);
    readCheck("R10 word13 partial", 13);
    check("R10 word13 value", int'(regRdData), 16'h0044);

    // R3 level beats index
    regWrite(0, 16'h4441);
    regWrite(10, 16'h7444);
    drive("R3 idx43 over idx0", bits2(0, 43), '1, 0);
    check("R3 winner 43", int'(winIdx), 43);
    check("R5 vector 51", int'(winVec), 51);

    // R4 tie goes to lower index
    drive("R4 tie", bits2(5, 9), '1, 0);
    check("R4 winner 5", int'(winIdx), 5);

    // R2 level 0 and disabled
    regWrite(1, 16'h4404);
    drive("R2 level0 skipped", bits2(5, 9), '1, 0);
    check("R2 winner 9", int'(winIdx), 9);
    drive("R2 disabled", bits2(9, 9), '0, 0);
    check("R2 none level", int'(winLvl), 0);

    // R6 reserved, R5 idle zeros
    drive("R6 reserved", bits2(30, 50), '1, 0);
    check("R6 none vec", int'(winVec), 0);

    // R7 strict compare, combinational
    drive("R7 equal", bits2(9, 9), '1, 4);
    check("R7 equal no req", int'(irqReq), 0);
    cpuLevel = 3'd3; #1;
    check("R7 below raises req", int'(irqReq), 1);

    // R8 and R9 timing
    drive("R8 setup", bits2(9, 10), '1, 0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd2; regWrData = 16'h4744;
    @(negedge clk);
    regWrEn = 1'b0;
    check("R9 old level same edge", int'(winIdx), 9);
    mdl[10] = 7;
    @(negedge clk);
    check("R9 new level next edge", int'(winIdx), 10);
    pending = bits2(0, 0); #1;
    check("R8 latency holds", int'(winIdx), 10);
    @(negedge clk);
    check("R8 after edge", int'(winIdx), 0);

    // R9 nibble top bit, R10 unused addresses
    regWrite(3, 16'hFFFF);
    readCheck("R9 top bits zero", 3);
    check("R9 word3 value", int'(regRdData), 16'h7777);
    regWrite(13, 16'hFFFF);
    readCheck("R10 word13 after write", 13);
    check("R10 word13 value", int'(regRdData), 16'h0077);
    regWrite(15, 16'hFFFF);
    readCheck("R10 addr15", 15);
    check("R10 addr15 value", int'(regRdData), 0);
    readCheck("R10 addr14", 14);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [N-1:0] p;
      logic [N-1:0] e;
      if (it % 4 == 0) regWrite(int'($urandom_range(15)), int'($urandom_range(16'hFFFF)));
      p = {$urandom, $urandom};
      e = {$urandom, $urandom};
      if (it % 3 == 0) e = '1;
      drive("R3/R4 random", p, e, int'($urandom_range(7)));
      if (it % 16 == 0) readCheck("R9 random read", int'($urandom_range(15)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule